// File: doc/BRIEF.md
# Double-Ended Ring Queue Manager

This block owns one ring of fixed-size slots held in on-chip storage and runs it as a double-ended queue. A requester issues one command per cycle: add an entry at the tail, take one from the head, add one in front of the head, or take one back from the tail. The block keeps the head index, the tail index and the occupancy. It reports the occupancy, the free slot count and a full flag. Because the block alone holds this state, commands from several requesters are applied strictly one after the other, in the order the block accepts them.

A configuration command sets the ring length in slots, a coded element size and an operating mode. The mode decides which commands are legal and whether an entry fills one slot or two. In two-slot modes the second slot carries an auxiliary word, such as a credential or a credential plus packet length. Two maintenance commands are provided. A ring reset empties the ring and keeps its configuration. A preload reset zeroes both indices and loads the occupancy with a given value, for rings whose contents a DMA engine will read.

Top module: `ringq_top`

## Requirements
- R1: A configuration write is accepted only when all of the following hold: the mode code is 0 (exposed ring), 1 (message), 2 (credentials) or 3 (queue manager); the element size code is 0..6, meaning 4, 8, 16, 32, 64, 128 or 256 bytes; the length is 1..MAX_SLOTS; the length is even in modes 2 and 3; and mode 3 uses size code 1 (8 bytes). An accepted write empties the ring and zeroes both indices. A rejected write returns an error and changes neither the configuration nor the ring.
- R2: Command codes are 0 for tail push, 1 for head pop, 2 for head push and 3 for tail pop. Entries pushed at the tail are popped at the head in first-in first-out order.
- R3: In exposed-ring mode (code 0), codes 2 and 3 return an error and leave the ring unchanged.
- R4: In message mode, an entry pushed at the head is the next one popped from the head, and a tail pop returns the newest entry pushed at the tail.
- R5: In modes 2 and 3 each entry takes two slots, and a pop returns the auxiliary word with the data word. In modes 0 and 1 an entry takes one slot, and the auxiliary output of a pop is zero.
- R6: The free count equals the length minus the occupancy. The full flag is high exactly when the free count is smaller than the number of slots one entry takes.
- R7: A push when full, or a pop when fewer slots are occupied than one entry takes, returns an error and leaves the occupancy and both indices unchanged.
- R8: Indices wrap modulo the configured length. A tail push and a head pop advance their index. A head push and a tail pop step their index back.
- R9: A ring reset zeroes the occupancy and both indices and keeps the configuration.
- R10: A preload reset zeroes both indices and loads the occupancy with the supplied value. A value larger than the length is refused with an error and changes nothing.
- R11: Every command raises done for exactly one cycle, on the cycle after it is issued, with error alongside when it is refused. When several commands arrive in one cycle, only one is applied, in this order of precedence: configuration, then preload reset, then ring reset, then queue command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write |
| cfg_size_i | input | CNT_W | Ring length in slots |
| cfg_elsz_i | input | 3 | Element size code |
| cfg_mode_i | input | 3 | Mode code |
| ring_rst_i | input | 1 | Ring reset command |
| dma_rst_i | input | 1 | Preload reset command |
| dma_occ_i | input | CNT_W | Occupancy to preload |
| op_valid_i | input | 1 | Queue command valid |
| op_code_i | input | 2 | Queue command code |
| op_data_i | input | DATA_W | Data word to push |
| op_aux_i | input | DATA_W | Auxiliary word to push (two-slot modes) |
| done_o | output | 1 | Command completion pulse |
| err_o | output | 1 | Command refused, valid with done_o |
| rd_data_o | output | DATA_W | Popped data word |
| rd_aux_o | output | DATA_W | Popped auxiliary word |
| occ_o | output | CNT_W | Occupied slots |
| free_o | output | CNT_W | Free slots |
| full_o | output | 1 | No room for another entry |
| head_o | output | IDX_W | Head slot index |
| tail_o | output | IDX_W | Tail slot index |

## Verification
Every command's results are registered. Done, error, the popped words, and the new occupancy, free count, full flag and indices all appear together one cycle after the command is driven. The bench drives each command on a falling edge and records the expected outcome in a scoreboard at that moment. A monitor samples one nanosecond after the following rising edge, removes one expected record for each done pulse, and compares every field. A done pulse with no pending record, or a pending record with no done pulse, counts as a failure.

// File: rtl/ringq_pkg.sv
package ringq_pkg;
  typedef enum logic [1:0] {
    OP_PUSH_TAIL = 2'd0,
    OP_POP_HEAD  = 2'd1,
    OP_PUSH_HEAD = 2'd2,
    OP_POP_TAIL  = 2'd3
  } ringq_op_e;

  localparam logic [1:0] MODE_EXPOSED = 2'd0;
  localparam logic [1:0] MODE_MSG     = 2'd1;
  localparam logic [2:0] MODE_LAST    = 3'd3;
  localparam logic [2:0] MODE_QMGR    = 3'd3;
  localparam logic [2:0] ELSZ_8B      = 3'd1;
  localparam logic [2:0] ELSZ_LAST    = 3'd6;
endpackage

// File: rtl/ringq_cfg.sv
module ringq_cfg #(
  parameter int MAX_SLOTS = 16,
  parameter int CNT_W     = $clog2(MAX_SLOTS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] size_i,
  input  logic [2:0]       elsz_i,
  input  logic [2:0]       mode_i,
  output logic             ok_o,
  output logic [CNT_W-1:0] size_o,
  output logic [1:0]       mode_o
);
  import ringq_pkg::*;

  logic [CNT_W-1:0] size_q;
  logic [1:0]       mode_q;
  logic             two_slot;

  assign two_slot = mode_i[1];

  always_comb begin
    ok_o = (mode_i <= MODE_LAST) && (elsz_i <= ELSZ_LAST) &&
           (size_i != '0) && (size_i <= CNT_W'(MAX_SLOTS));
    if (two_slot && size_i[0]) ok_o = 1'b0;
    if (mode_i == MODE_QMGR && elsz_i != ELSZ_8B) ok_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= CNT_W'(MAX_SLOTS);
      mode_q <= MODE_MSG;
    end else if (we_i && ok_o) begin
      size_q <= size_i;
      mode_q <= mode_i[1:0];
    end
  end

  assign size_o = size_q;
  assign mode_o = mode_q;

  assert_cfg_reject_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !ok_o) |=> ($stable(size_q) && $stable(mode_q)));
endmodule

// File: rtl/ringq_store.sv
module ringq_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_a_i,
  input  logic              we_b_i,
  input  logic [IDX_W-1:0]  addr_a_i,
  input  logic [IDX_W-1:0]  addr_b_i,
  input  logic [DATA_W-1:0] wd_a_i,
  input  logic [DATA_W-1:0] wd_b_i,
  input  logic              rd_en_i,
  input  logic              two_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we_a_i && addr_a_i == IDX_W'(i))      mem_q[i] <= wd_a_i;
      else if (we_b_i && addr_b_i == IDX_W'(i)) mem_q[i] <= wd_b_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_a_o <= '0;
      rd_b_o <= '0;
    end else if (rd_en_i) begin
      rd_a_o <= mem_q[addr_a_i];
      rd_b_o <= two_i ? mem_q[addr_b_i] : '0;
    end
  end
endmodule

// File: rtl/ringq_ctrl.sv
module ringq_ctrl #(
  parameter int MAX_SLOTS = 16,
  parameter int IDX_W     = $clog2(MAX_SLOTS),
  parameter int CNT_W     = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_ok_i,
  input  logic [CNT_W-1:0] size_i,
  input  logic [1:0]       mode_i,
  input  logic             dma_rst_i,
  input  logic [CNT_W-1:0] dma_occ_i,
  input  logic             ring_rst_i,
  input  logic             op_valid_i,
  input  logic [1:0]       op_code_i,
  output logic             we_a_o,
  output logic             we_b_o,
  output logic             rd_en_o,
  output logic             two_o,
  output logic [IDX_W-1:0] slot_a_o,
  output logic [IDX_W-1:0] slot_b_o,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] occ_o,
  output logic [CNT_W-1:0] free_o,
  output logic             full_o,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o
);
  import ringq_pkg::*;

  logic [CNT_W-1:0] occ_q, nxt_occ, spe;
  logic [IDX_W-1:0] head_q, tail_q, nxt_head, nxt_tail, slot_a;
  logic             sel_cfg, sel_dma, sel_rst, sel_op;
  logic             is_push, op_err, op_go, dma_bad, done_d, err_d;
  ringq_op_e        op;

  function automatic logic [IDX_W-1:0] idx_add(input logic [IDX_W-1:0] i,
                                               input logic [CNT_W-1:0] n,
                                               input logic [CNT_W-1:0] sz);
    logic [CNT_W-1:0] s;
    s = {1'b0, i} + n;
    if (s >= sz) s = s - sz;
    return s[IDX_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] idx_sub(input logic [IDX_W-1:0] i,
                                               input logic [CNT_W-1:0] n,
                                               input logic [CNT_W-1:0] sz);
    logic [CNT_W-1:0] s;
    if ({1'b0, i} < n) s = {1'b0, i} + sz - n;
    else               s = {1'b0, i} - n;
    return s[IDX_W-1:0];
  endfunction

  assign op      = ringq_op_e'(op_code_i);
  assign two_o   = mode_i[1];
  assign spe     = two_o ? CNT_W'(2) : CNT_W'(1);
  assign free_o  = size_i - occ_q;
  assign full_o  = free_o < spe;
  assign is_push = (op == OP_PUSH_TAIL) || (op == OP_PUSH_HEAD);

  // fixed precedence: config > preload reset > ring reset > queue op
  assign sel_cfg = cfg_we_i;
  assign sel_dma = !cfg_we_i && dma_rst_i;
  assign sel_rst = !cfg_we_i && !dma_rst_i && ring_rst_i;
  assign sel_op  = !cfg_we_i && !dma_rst_i && !ring_rst_i && op_valid_i;

  assign dma_bad = dma_occ_i > size_i;
  assign op_err  = (mode_i == MODE_EXPOSED && op_code_i[1]) ||
                   (is_push ? full_o : (occ_q < spe));
  assign op_go   = sel_op && !op_err;

  always_comb begin
    slot_a   = head_q;
    nxt_head = head_q;
    nxt_tail = tail_q;
    nxt_occ  = occ_q;
    unique case (op)
      OP_PUSH_TAIL: begin
        slot_a   = tail_q;
        nxt_tail = idx_add(tail_q, spe, size_i);
        nxt_occ  = occ_q + spe;
      end
      OP_POP_HEAD: begin
        slot_a   = head_q;
        nxt_head = idx_add(head_q, spe, size_i);
        nxt_occ  = occ_q - spe;
      end
      OP_PUSH_HEAD: begin
        slot_a   = idx_sub(head_q, spe, size_i);
        nxt_head = slot_a;
        nxt_occ  = occ_q + spe;
      end
      default: begin
        slot_a   = idx_sub(tail_q, spe, size_i);
        nxt_tail = slot_a;
        nxt_occ  = occ_q - spe;
      end
    endcase
  end

  assign slot_a_o = slot_a;
  assign slot_b_o = idx_add(slot_a, CNT_W'(1), size_i);
  assign we_a_o   = op_go && is_push;
  assign we_b_o   = op_go && is_push && two_o;
  assign rd_en_o  = op_go && !is_push;

  assign done_d = sel_cfg || sel_dma || sel_rst || sel_op;
  assign err_d  = (sel_cfg && !cfg_ok_i) || (sel_dma && dma_bad) || (sel_op && op_err);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= done_d;
      err_o  <= err_d;
      if ((sel_cfg && cfg_ok_i) || sel_rst) begin
        occ_q  <= '0;
        head_q <= '0;
        tail_q <= '0;
      end else if (sel_dma && !dma_bad) begin
        occ_q  <= dma_occ_i;
        head_q <= '0;
        tail_q <= '0;
      end else if (op_go) begin
        occ_q  <= nxt_occ;
        head_q <= nxt_head;
        tail_q <= nxt_tail;
      end
    end
  end

  assign occ_o  = occ_q;
  assign head_o = head_q;
  assign tail_o = tail_q;

  assert_occ_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= size_i);
  assert_refused_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_op && op_err) |=> ($stable(occ_q) && $stable(head_q) && $stable(tail_q)));
  assert_exposed_refuse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_op && mode_i == MODE_EXPOSED && op_code_i[1]) |=> err_o);
  assert_push_grow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_go && is_push) |=> (occ_q == $past(occ_q) + $past(spe)));
  assert_ring_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rst |=> (occ_q == '0 && head_q == '0 && tail_q == '0));
  assert_preload_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_dma && !dma_bad) |=> (occ_q == $past(dma_occ_i)));
endmodule

// File: rtl/ringq_top.sv
module ringq_top #(
  parameter int MAX_SLOTS = 16,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = $clog2(MAX_SLOTS),
  parameter int CNT_W     = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CNT_W-1:0]  cfg_size_i,
  input  logic [2:0]        cfg_elsz_i,
  input  logic [2:0]        cfg_mode_i,
  input  logic              ring_rst_i,
  input  logic              dma_rst_i,
  input  logic [CNT_W-1:0]  dma_occ_i,
  input  logic              op_valid_i,
  input  logic [1:0]        op_code_i,
  input  logic [DATA_W-1:0] op_data_i,
  input  logic [DATA_W-1:0] op_aux_i,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] rd_aux_o,
  output logic [CNT_W-1:0]  occ_o,
  output logic [CNT_W-1:0]  free_o,
  output logic              full_o,
  output logic [IDX_W-1:0]  head_o,
  output logic [IDX_W-1:0]  tail_o
);
  logic             cfg_ok, we_a, we_b, rd_en, two;
  logic [CNT_W-1:0] size;
  logic [1:0]       mode;
  logic [IDX_W-1:0] slot_a, slot_b;

  ringq_cfg #(.MAX_SLOTS(MAX_SLOTS), .CNT_W(CNT_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .size_i (cfg_size_i),
    .elsz_i (cfg_elsz_i),
    .mode_i (cfg_mode_i),
    .ok_o   (cfg_ok),
    .size_o (size),
    .mode_o (mode)
  );

  ringq_ctrl #(.MAX_SLOTS(MAX_SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_ok_i   (cfg_ok),
    .size_i     (size),
    .mode_i     (mode),
    .dma_rst_i  (dma_rst_i),
    .dma_occ_i  (dma_occ_i),
    .ring_rst_i (ring_rst_i),
    .op_valid_i (op_valid_i),
    .op_code_i  (op_code_i),
    .we_a_o     (we_a),
    .we_b_o     (we_b),
    .rd_en_o    (rd_en),
    .two_o      (two),
    .slot_a_o   (slot_a),
    .slot_b_o   (slot_b),
    .done_o     (done_o),
    .err_o      (err_o),
    .occ_o      (occ_o),
    .free_o     (free_o),
    .full_o     (full_o),
    .head_o     (head_o),
    .tail_o     (tail_o)
  );

  ringq_store #(.DEPTH(MAX_SLOTS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_a_i   (we_a),
    .we_b_i   (we_b),
    .addr_a_i (slot_a),
    .addr_b_i (slot_b),
    .wd_a_i   (op_data_i),
    .wd_b_i   (op_aux_i),
    .rd_en_i  (rd_en),
    .two_i    (two),
    .rd_a_o   (rd_data_o),
    .rd_b_o   (rd_aux_o)
  );

  assert_done_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i || dma_rst_i || ring_rst_i || op_valid_i) |=> done_o);
  assert_err_needs_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

// File: tb/sim_ringq_top.sv
module sim_ringq_top;
  localparam int MAX_SLOTS = 16;
  localparam int DATA_W    = 32;
  localparam int IDX_W     = $clog2(MAX_SLOTS);
  localparam int CNT_W     = IDX_W + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we, ring_rst, dma_rst, op_valid;
  logic [CNT_W-1:0]  cfg_size, dma_occ;
  logic [2:0]        cfg_elsz, cfg_mode;
  logic [1:0]        op_code;
  logic [DATA_W-1:0] op_data, op_aux;
  logic              done, err, full;
  logic [DATA_W-1:0] rd_data, rd_aux;
  logic [CNT_W-1:0]  occ, free_cnt;
  logic [IDX_W-1:0]  head, tail;

  always #2 clk = ~clk;

  ringq_top #(.MAX_SLOTS(MAX_SLOTS), .DATA_W(DATA_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_size_i(cfg_size),
    .cfg_elsz_i(cfg_elsz), .cfg_mode_i(cfg_mode), .ring_rst_i(ring_rst),
    .dma_rst_i(dma_rst), .dma_occ_i(dma_occ), .op_valid_i(op_valid),
    .op_code_i(op_code), .op_data_i(op_data), .op_aux_i(op_aux),
    .done_o(done), .err_o(err), .rd_data_o(rd_data), .rd_aux_o(rd_aux),
    .occ_o(occ), .free_o(free_cnt), .full_o(full), .head_o(head), .tail_o(tail)
  );

  typedef struct {
    bit    err;
    bit    chk_data;
    int    data;
    int    aux;
    int    occ;
    int    head;
    int    tail;
    int    size;
    int    spe;
    string req;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] dq[$];
  int m_size = MAX_SLOTS, m_mode = 1, m_occ = 0, m_head = 0, m_tail = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int m_spe();
    return (m_mode >= 2) ? 2 : 1;
  endfunction

  task automatic post(bit e, bit cd, int d, int a, string req);
    exp_t x;
    x.err = e; x.chk_data = cd; x.data = d; x.aux = a;
    x.occ = m_occ; x.head = m_head; x.tail = m_tail;
    x.size = m_size; x.spe = m_spe(); x.req = req;
    sb.push_back(x);
  endtask

  task automatic idle();
    cfg_we = 0; ring_rst = 0; dma_rst = 0; op_valid = 0;
    cfg_size = '0; cfg_elsz = '0; cfg_mode = '0; dma_occ = '0;
    op_code = '0; op_data = '0; op_aux = '0;
  endtask

  task automatic t_cfg(int sz, int el, int md, bit with_op, string req);
    bit ok;
    ok = (md <= 3) && (el <= 6) && (sz >= 1) && (sz <= MAX_SLOTS) &&
         !(md >= 2 && (sz % 2) != 0) && !(md == 3 && el != 1);
    if (ok) begin
      m_size = sz; m_mode = md; m_occ = 0; m_head = 0; m_tail = 0; dq.delete();
    end
    cfg_we = 1; cfg_size = CNT_W'(sz); cfg_elsz = 3'(el); cfg_mode = 3'(md);
    if (with_op) begin op_valid = 1; op_code = 2'd0; op_data = 32'hDEAD; end
    post(!ok, 0, 0, 0, req);
    @(negedge clk); idle();
  endtask

  task automatic t_rst(string req);
    m_occ = 0; m_head = 0; m_tail = 0; dq.delete();
    ring_rst = 1;
    post(0, 0, 0, 0, req);
    @(negedge clk); idle();
  endtask

  task automatic t_dma(int o, string req);
    bit e;
    e = o > m_size;
    if (!e) begin m_occ = o; m_head = 0; m_tail = 0; dq.delete(); end
    dma_rst = 1; dma_occ = CNT_W'(o);
    post(e, 0, 0, 0, req);
    @(negedge clk); idle();
  endtask

  task automatic t_op(int code, int d, int a, string req);
    bit e = 0, cd = 0;
    int spe = m_spe(), rd = 0, ra = 0;
    logic [63:0] ent;
    if (m_mode == 0 && code >= 2) e = 1;
    else if (code == 0 || code == 2) begin
      if (m_size - m_occ < spe) e = 1;
      else begin
        ent = {32'(d), (spe == 2) ? 32'(a) : 32'd0};
        if (code == 0) begin dq.push_back(ent);  m_tail = (m_tail + spe) % m_size; end
        else           begin dq.push_front(ent); m_head = (m_head - spe + m_size) % m_size; end
        m_occ += spe;
      end
    end else begin
      if (m_occ < spe) e = 1;
      else begin
        if (dq.size() > 0) begin
          ent = (code == 1) ? dq.pop_front() : dq.pop_back();
          cd = 1; rd = int'(ent[63:32]); ra = int'(ent[31:0]);
        end
        if (code == 1) m_head = (m_head + spe) % m_size;
        else           m_tail = (m_tail - spe + m_size) % m_size;
        m_occ -= spe;
      end
    end
    op_valid = 1; op_code = 2'(code); op_data = 32'(d); op_aux = 32'(a);
    post(e, cd, rd, ra, req);
    @(negedge clk); idle();
  endtask

  // monitor: results are due one cycle after the command edge
  initial begin
    exp_t x;
    forever begin
      @(posedge clk); #1;
      if (rst_n && !finished) begin
        if (done) begin
          if (sb.size() == 0) chk(0, "R11", "unexpected done", 1, 0);
          else begin
            x = sb.pop_front();
            chk(err == x.err, x.req, "err", int'(err), int'(x.err));
            if (x.chk_data) begin
              chk(rd_data == 32'(x.data), x.req, "rd_data", int'(rd_data), x.data);
              chk(rd_aux == 32'(x.aux), x.req, "rd_aux", int'(rd_aux), x.aux);
            end
            chk(int'(occ) == x.occ, x.req, "occ", int'(occ), x.occ);
            chk(int'(free_cnt) == x.size - x.occ, "R6", "free", int'(free_cnt), x.size - x.occ);
            chk(full == ((x.size - x.occ) < x.spe), "R6", "full", int'(full),
                int'((x.size - x.occ) < x.spe));
            chk(int'(head) == x.head, x.req, "head", int'(head), x.head);
            chk(int'(tail) == x.tail, x.req, "tail", int'(tail), x.tail);
          end
        end else if (sb.size() != 0) begin
          chk(0, "R11", "missing done", 0, 1);
          void'(sb.pop_front());
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    chk(0, "R11", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R6, R9)
    chk(done == 0, "R11", "reset done", int'(done), 0);
    chk(occ == 0, "R9", "reset occ", int'(occ), 0);
    chk(int'(free_cnt) == MAX_SLOTS, "R6", "reset free", int'(free_cnt), MAX_SLOTS);
    chk(full == 0, "R6", "reset full", int'(full), 0);
    chk(head == 0 && tail == 0, "R9", "reset idx", int'(head) + int'(tail), 0);

    // R2, R4: message-mode deque behaviour
    t_op(0, 11, 0, "R2");
    t_op(0, 22, 0, "R2");
    t_op(0, 33, 0, "R2");
    t_op(1, 0, 0, "R2");
    t_op(2, 44, 0, "R4");
    t_op(1, 0, 0, "R4");
    t_op(3, 0, 0, "R4");
    t_op(1, 0, 0, "R2");
    t_op(1, 0, 0, "R7");
    t_op(3, 0, 0, "R7");

    // R3, R8: exposed ring, length 5
    t_cfg(5, 2, 0, 0, "R1");
    t_op(2, 7, 0, "R3");
    for (int i = 0; i < 3; i++) t_op(0, 100 + i, 0, "R8");
    for (int i = 0; i < 3; i++) t_op(1, 0, 0, "R8");
    for (int i = 0; i < 5; i++) t_op(0, 200 + i, 0, "R8");
    t_op(0, 999, 0, "R7");
    t_op(3, 0, 0, "R3");
    for (int i = 0; i < 5; i++) t_op(1, 0, 0, "R8");

    // R1: rejected configurations keep length 5 and the ring
    t_op(0, 300, 0, "R1");
    t_cfg(5, 2, 4, 0, "R1");
    t_cfg(5, 7, 1, 0, "R1");
    t_cfg(0, 2, 1, 0, "R1");
    t_cfg(17, 2, 1, 0, "R1");
    t_cfg(5, 2, 2, 0, "R1");
    t_cfg(4, 2, 3, 0, "R1");
    t_op(1, 0, 0, "R1");

    // R5: credentials mode, two slots per entry
    t_cfg(6, 3, 2, 0, "R1");
    for (int i = 0; i < 3; i++) t_op(0, 400 + i, 500 + i, "R5");
    t_op(0, 1, 2, "R7");
    t_op(1, 0, 0, "R5");
    t_op(2, 410, 510, "R5");
    t_op(3, 0, 0, "R5");
    t_op(1, 0, 0, "R5");
    t_op(1, 0, 0, "R5");
    t_op(1, 0, 0, "R7");

    // R5: queue-manager mode, 8-byte elements
    t_cfg(4, 1, 3, 0, "R1");
    t_op(0, 600, 700, "R5");
    t_op(2, 601, 701, "R5");
    t_op(0, 602, 702, "R7");
    t_op(3, 0, 0, "R5");
    t_op(3, 0, 0, "R5");

    // R9: ring reset keeps length 4 and mode
    t_op(0, 800, 900, "R9");
    t_rst("R9");
    t_op(0, 801, 901, "R9");
    t_op(1, 0, 0, "R9");

    // R10: preload reset
    t_dma(3, "R10");
    t_dma(5, "R10");
    t_rst("R10");

    // R11: back-to-back and precedence
    t_cfg(8, 0, 1, 1, "R11");
    t_op(0, 1000, 0, "R11");
    t_op(1, 0, 0, "R11");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11", "scoreboard drained", sb.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule